// File: doc/BRIEF.md
# Multi-Source Reset Controller

The block gathers every reset request a small processor system can raise (power-on, the external reset pin, a software reset command, watchdog expiry, brown-out, trap conflict, illegal opcode, use of an uninitialized working register and a configuration mismatch) and drives a single active-high system reset. Digital sources assert the reset in the same cycle they arrive. The reset is held for a fixed number of clock cycles after the last source goes away and is always released on a clock edge.

Each reset cause leaves a sticky flag in a status register that software can read and overwrite at will. Power-on is special: it clears every cause flag except the power-on and brown-out flags, and sets both of those. A 2-bit brown-out mode input, a software enable bit kept in the same register and the sleep indicator together decide whether a brown-out event may reset the system. The external pin is synchronized and filtered so that short glitches never reach the reset.

Top module: `reset_ctrl`

## Requirements
- R1: `sys_rst_o` is high in any cycle in which `por_i`, `sw_rst_i`, `wdog_i`, `trap_i`, `illegal_op_i`, `uninit_w_i`, `cfg_mismatch_i`, a permitted brown-out or the filtered pin request is active.
- R2: Each cause sets its own flag on the clock edge at which it is sampled: bit 1 brown-out, bit 2 pin, bit 3 software, bit 4 watchdog, bit 5 trap, bit 6 illegal opcode, bit 7 uninitialized register, bit 8 configuration mismatch; causes active together all set their flags.
- R3: A clock edge with `por_i` high loads the status register with 10'h203: bit 0 (power-on) and bit 1 (brown-out) set, bit 9 (software brown-out enable) set, all other bits clear.
- R4: With `stat_we_i` high, `stat_wdata_i` replaces all 10 status bits at the next edge, with causes sampled at that edge ORed on top; a write never asserts `sys_rst_o`.
- R5: After every source has gone inactive, `sys_rst_o` stays high for exactly 16 more clock edges and falls after the 16th.
- R6: Brown-out mode `brn_cfg_i`: 00 never resets; 01 resets only when status bit 9 is 1; 10 resets only while `sleep_i` is 0; 11 always resets. A blocked brown-out neither resets nor sets bit 1.
- R7: `pin_rst_n_i` passes a 2-flop synchronizer; a pin request is raised only after 4 consecutive low synchronized samples and held while the pin stays low; shorter low pulses have no effect on reset or bit 2.
- R8: Outside power-on and software writes, no status bit ever clears, so flags survive non-power-on resets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| por_i | input | 1 | Power-on reset request, also initializes the block |
| pin_rst_n_i | input | 1 | External reset pin, active low, asynchronous |
| sw_rst_i | input | 1 | Software reset command pulse |
| wdog_i | input | 1 | Watchdog timeout pulse |
| brownout_i | input | 1 | Brown-out detect event |
| trap_i | input | 1 | Trap conflict event |
| illegal_op_i | input | 1 | Illegal opcode event |
| uninit_w_i | input | 1 | Uninitialized working register event |
| cfg_mismatch_i | input | 1 | Configuration mismatch event |
| sleep_i | input | 1 | High while the system sleeps |
| brn_cfg_i | input | 2 | Brown-out reset mode |
| stat_we_i | input | 1 | Status register write strobe |
| stat_wdata_i | input | 10 | Status register write data |
| sys_rst_o | output | 1 | System reset, active high |
| status_o | output | 10 | Status register contents |

## Verification
The bench targets pin pulses of exactly three and exactly four filtered samples; a filter counting one too few would reset on the glitch, one too many would miss the genuine press. It checks each brown-out mode with the software enable and sleep on both sides, where a wrong decode would either reset during sleep or set the brown-out flag without a reset. It also runs simultaneous causes, a write landing next to a cause, and a watchdog reset followed by a software reset, where a controller that clears flags on every reset would lose the earlier cause, and it counts the stretch edges exactly so an off-by-one release is seen.

// File: rtl/reset_ctrl_pkg.sv
package reset_ctrl_pkg;
  localparam int NUM_CAUSE = 9;
  localparam int STAT_W    = NUM_CAUSE + 1;

  localparam int B_PWR  = 0;
  localparam int B_BRN  = 1;
  localparam int B_PIN  = 2;
  localparam int B_SW   = 3;
  localparam int B_WDOG = 4;
  localparam int B_TRAP = 5;
  localparam int B_ILL  = 6;
  localparam int B_UNW  = 7;
  localparam int B_CFG  = 8;
  localparam int B_BSWEN = 9;

  typedef enum logic [1:0] {
    BRN_OFF   = 2'b00,
    BRN_SOFT  = 2'b01,
    BRN_AWAKE = 2'b10,
    BRN_ON    = 2'b11
  } brn_mode_e;
endpackage

// File: rtl/rc_pin_filter.sv
module rc_pin_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 4
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic pin_n_i,
  output logic req_o
);
  localparam int CW = $clog2(FILT_LEN + 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [CW-1:0]          low_cnt_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) sync_q <= '1;
    else       sync_q <= {sync_q[SYNC_STAGES-2:0], pin_n_i};
  end

  always_ff @(posedge clk_i) begin
    if (rst_i)                            low_cnt_q <= '0;
    else if (sync_q[SYNC_STAGES-1])       low_cnt_q <= '0;
    else if (low_cnt_q != CW'(FILT_LEN))  low_cnt_q <= low_cnt_q + 1'b1;
  end

  assign req_o = (low_cnt_q == CW'(FILT_LEN));
endmodule

// File: rtl/rc_bor_gate.sv
module rc_bor_gate
  import reset_ctrl_pkg::*;
(
  input  logic [1:0] mode_i,
  input  logic       sw_en_i,
  input  logic       sleep_i,
  output logic       allow_o
);
  always_comb begin
    unique case (brn_mode_e'(mode_i))
      BRN_OFF:   allow_o = 1'b0;
      BRN_SOFT:  allow_o = sw_en_i;
      BRN_AWAKE: allow_o = ~sleep_i;
      BRN_ON:    allow_o = 1'b1;
      default:   allow_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/rc_stretch.sv
module rc_stretch #(
  parameter int HOLD_CYCLES = 16
) (
  input  logic clk_i,
  input  logic src_i,
  output logic hold_o
);
  localparam int HW = $clog2(HOLD_CYCLES + 1);

  logic [HW-1:0] left_q;

  always_ff @(posedge clk_i) begin
    if (src_i)              left_q <= HW'(HOLD_CYCLES);
    else if (left_q != '0)  left_q <= left_q - 1'b1;
  end

  assign hold_o = (left_q != '0);
endmodule

// File: rtl/reset_ctrl.sv
module reset_ctrl
  import reset_ctrl_pkg::*;
#(
  parameter int HOLD_CYCLES = 16,
  parameter int FILT_LEN    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              por_i,
  input  logic              pin_rst_n_i,
  input  logic              sw_rst_i,
  input  logic              wdog_i,
  input  logic              brownout_i,
  input  logic              trap_i,
  input  logic              illegal_op_i,
  input  logic              uninit_w_i,
  input  logic              cfg_mismatch_i,
  input  logic              sleep_i,
  input  logic [1:0]        brn_cfg_i,
  input  logic              stat_we_i,
  input  logic [STAT_W-1:0] stat_wdata_i,
  output logic              sys_rst_o,
  output logic [STAT_W-1:0] status_o
);
  logic                 pin_req;
  logic                 brn_allow;
  logic                 hold;
  logic                 src_any;
  logic [NUM_CAUSE-1:0] cause;
  logic [STAT_W-1:0]    status_q;
  logic [STAT_W-1:0]    status_d;
  logic [STAT_W-1:0]    base;

  rc_pin_filter #(.SYNC_STAGES(SYNC_STAGES), .FILT_LEN(FILT_LEN)) pin_i (
    .clk_i   (clk_i),
    .rst_i   (por_i),
    .pin_n_i (pin_rst_n_i),
    .req_o   (pin_req)
  );

  rc_bor_gate bor_i (
    .mode_i  (brn_cfg_i),
    .sw_en_i (status_q[B_BSWEN]),
    .sleep_i (sleep_i),
    .allow_o (brn_allow)
  );

  always_comb begin
    cause          = '0;
    cause[B_PWR]   = por_i;
    cause[B_BRN]   = brownout_i & brn_allow;
    cause[B_PIN]   = pin_req;
    cause[B_SW]    = sw_rst_i;
    cause[B_WDOG]  = wdog_i;
    cause[B_TRAP]  = trap_i;
    cause[B_ILL]   = illegal_op_i;
    cause[B_UNW]   = uninit_w_i;
    cause[B_CFG]   = cfg_mismatch_i;
  end

  assign src_any = |cause;

  rc_stretch #(.HOLD_CYCLES(HOLD_CYCLES)) str_i (
    .clk_i  (clk_i),
    .src_i  (src_any),
    .hold_o (hold)
  );

  always_comb begin
    base     = stat_we_i ? stat_wdata_i : status_q;
    status_d = base | {1'b0, cause};
  end

  always_ff @(posedge clk_i) begin
    if (por_i) begin
      status_q          <= '0;
      status_q[B_PWR]   <= 1'b1;
      status_q[B_BRN]   <= 1'b1;
      status_q[B_BSWEN] <= 1'b1;
    end else begin
      status_q <= status_d;
    end
  end

  assign sys_rst_o = src_any | hold;
  assign status_o  = status_q;
endmodule

// File: rtl/reset_ctrl_chk.sv
module reset_ctrl_chk
  import reset_ctrl_pkg::*;
#(
  parameter int HOLD_CYCLES = 16
) (
  input logic              clk_i,
  input logic              por_i,
  input logic              pin_rst_n_i,
  input logic              sw_rst_i,
  input logic              wdog_i,
  input logic              brownout_i,
  input logic              trap_i,
  input logic              illegal_op_i,
  input logic              uninit_w_i,
  input logic              cfg_mismatch_i,
  input logic [1:0]        brn_cfg_i,
  input logic              stat_we_i,
  input logic [STAT_W-1:0] stat_wdata_i,
  input logic              sys_rst_o,
  input logic [STAT_W-1:0] status_o
);
  localparam int QW = $clog2(HOLD_CYCLES + 2);
  localparam logic [STAT_W-1:0] POR_VAL = STAT_W'(10'h203);
  localparam logic [STAT_W-1:0] PIN_M   = STAT_W'(1) << B_PIN;

  logic          direct;
  logic          prev_por_q = 1'b0;
  logic [QW-1:0] quiet_q    = '0;

  assign direct = por_i | sw_rst_i | wdog_i | trap_i | illegal_op_i |
                  uninit_w_i | cfg_mismatch_i;

  always_ff @(posedge clk_i) begin
    prev_por_q <= por_i;
    if (direct) quiet_q <= QW'(1);
    else if (quiet_q != '0 && quiet_q <= QW'(HOLD_CYCLES)) quiet_q <= quiet_q + 1'b1;
  end

  AST_DIRECT_RESETS: assert property (@(posedge clk_i) disable iff (por_i)
    direct |-> sys_rst_o);  // R1
  AST_SW_FLAG: assert property (@(posedge clk_i) disable iff (por_i)
    sw_rst_i |=> status_o[B_SW]);  // R2
  AST_TRAP_FLAG: assert property (@(posedge clk_i) disable iff (por_i)
    trap_i |=> status_o[B_TRAP]);  // R2
  AST_POR_VALUE: assert property (@(posedge clk_i)
    prev_por_q |-> (status_o == POR_VAL));  // R3
  AST_WRITE_LANDS: assert property (@(posedge clk_i) disable iff (por_i)
    (stat_we_i && !direct && !brownout_i) |=>
      ((status_o & ~PIN_M) == ($past(stat_wdata_i) & ~PIN_M)));  // R4
  AST_HOLD_WINDOW: assert property (@(posedge clk_i) disable iff (por_i)
    (quiet_q != '0 && quiet_q <= QW'(HOLD_CYCLES)) |-> sys_rst_o);  // R5
  AST_BRN_OFF: assert property (@(posedge clk_i) disable iff (por_i)
    (brn_cfg_i == 2'b00 && !stat_we_i) |=>
      (status_o[B_BRN] == $past(status_o[B_BRN])));  // R6
  AST_FLAGS_STICKY: assert property (@(posedge clk_i) disable iff (por_i)
    !stat_we_i |=> ((status_o & $past(status_o)) == $past(status_o)));  // R8
endmodule

bind reset_ctrl reset_ctrl_chk #(.HOLD_CYCLES(HOLD_CYCLES)) chk_i (
  .clk_i          (clk_i),
  .por_i          (por_i),
  .pin_rst_n_i    (pin_rst_n_i),
  .sw_rst_i       (sw_rst_i),
  .wdog_i         (wdog_i),
  .brownout_i     (brownout_i),
  .trap_i         (trap_i),
  .illegal_op_i   (illegal_op_i),
  .uninit_w_i     (uninit_w_i),
  .cfg_mismatch_i (cfg_mismatch_i),
  .brn_cfg_i      (brn_cfg_i),
  .stat_we_i      (stat_we_i),
  .stat_wdata_i   (stat_wdata_i),
  .sys_rst_o      (sys_rst_o),
  .status_o       (status_o)
);

// File: tb/reset_ctrl_tb_top.sv
`timescale 1ns/1ps
module reset_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       por = 1'b1, pin_n = 1'b1, swr = 1'b0, wdt = 1'b0, brn = 1'b0;
  logic       trap = 1'b0, ill = 1'b0, unw = 1'b0, cfgm = 1'b0, slp = 1'b0;
  logic [1:0] bcfg = 2'b11;
  logic       we = 1'b0;
  logic [9:0] wdata = '0;
  logic       rst;
  logic [9:0] stat;

  int checks = 0;
  int fails  = 0;
  bit started = 0;
  string cur_req = "R3";

  // behavioural reference state
  bit [9:0] m_stat;
  int m_s1, m_s2, m_low, m_left;

  always #10 clk = ~clk;

  reset_ctrl dut_i (
    .clk_i(clk), .por_i(por), .pin_rst_n_i(pin_n), .sw_rst_i(swr),
    .wdog_i(wdt), .brownout_i(brn), .trap_i(trap), .illegal_op_i(ill),
    .uninit_w_i(unw), .cfg_mismatch_i(cfgm), .sleep_i(slp),
    .brn_cfg_i(bcfg), .stat_we_i(we), .stat_wdata_i(wdata),
    .sys_rst_o(rst), .status_o(stat)
  );

  function automatic bit brn_ok();
    case (bcfg)
      2'b00: return 1'b0;
      2'b01: return m_stat[9];
      2'b10: return !slp;
      default: return 1'b1;
    endcase
  endfunction

  function automatic bit [8:0] m_causes();
    bit [8:0] c = '0;
    c[0] = por; c[1] = brn && brn_ok(); c[2] = (m_low >= 4);
    c[3] = swr; c[4] = wdt; c[5] = trap; c[6] = ill; c[7] = unw; c[8] = cfgm;
    return c;
  endfunction

  function automatic bit m_rst();
    return (|m_causes()) || (m_left > 0);
  endfunction

  always @(posedge clk) begin
    bit [8:0] c;
    c = m_causes();
    if (por) begin
      m_stat = 10'h203; m_s1 = 1; m_s2 = 1; m_low = 0; m_left = 16;
    end else begin
      m_stat = (we ? wdata : m_stat) | {1'b0, c};
      if (m_s2 != 0) m_low = 0; else if (m_low < 4) m_low++;
      m_s2 = m_s1; m_s1 = pin_n;
      if (|c) m_left = 16; else if (m_left > 0) m_left--;
    end
    started = 1;
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
    if (started) begin
      chk({cur_req, " status vs model"}, 32'(stat), 32'(m_stat));
      chk({cur_req, " reset vs model"}, 32'(rst), 32'(m_rst()));
    end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  initial begin
    #(20 * 5000);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int n;
    @(negedge clk);
    idle(3);
    chk("R3 power-on value", 32'(stat), 32'h203);
    chk("R1 reset during power-on", 32'(rst), 1);
    por = 1'b0;
    cur_req = "R5";
    n = 0;
    while (rst === 1'b1 && n < 40) begin cyc(); n++; end
    chk("R5 stretch length", n, 16);
    idle(3);

    cur_req = "R4";
    we = 1'b1; wdata = 10'h200; cyc(); we = 1'b0;
    chk("R4 write clears flags", 32'(stat), 32'h200);
    we = 1'b1; wdata = 10'h3FC; cyc(); we = 1'b0;
    chk("R4 write sets flags", 32'(stat), 32'h3FC);
    chk("R4 write causes no reset", 32'(rst), 0);
    idle(2);
    we = 1'b1; wdata = 10'h200; cyc(); we = 1'b0; idle(2);

    cur_req = "R2";
    swr = 1'b1;
    @(posedge clk); #1;
    chk("R1 software reset immediate", 32'(rst), 1);
    @(negedge clk); swr = 1'b0;
    chk("R2 software flag", 32'(stat[3]), 1);
    idle(20);
    wdt = 1'b1; trap = 1'b1; cyc(); wdt = 1'b0; trap = 1'b0;
    chk("R2 simultaneous watchdog and trap", 32'(stat), 32'h238);
    idle(20);
    ill = 1'b1; unw = 1'b1; cfgm = 1'b1; cyc(); ill = 1'b0; unw = 1'b0; cfgm = 1'b0;
    chk("R8 earlier flags kept", 32'(stat), 32'h3F8);
    idle(20);

    cur_req = "R4";
    we = 1'b1; wdata = 10'h200; swr = 1'b1; cyc(); we = 1'b0; swr = 1'b0;
    chk("R4 cause ORed over write", 32'(stat), 32'h208);
    idle(20);
    we = 1'b1; wdata = 10'h200; cyc(); we = 1'b0; idle(2);

    cur_req = "R7";
    pin_n = 1'b0; idle(3); pin_n = 1'b1; idle(8);
    chk("R7 short pulse ignored flag", 32'(stat[2]), 0);
    chk("R7 short pulse ignored reset", 32'(rst), 0);
    pin_n = 1'b0; idle(4); pin_n = 1'b1; idle(3);
    chk("R7 four-sample press", 32'(stat[2]), 1);
    chk("R7 four-sample press resets", 32'(rst), 1);
    idle(20);

    cur_req = "R6";
    we = 1'b1; wdata = 10'h000; cyc(); we = 1'b0;
    bcfg = 2'b00; brn = 1'b1; cyc(); brn = 1'b0;
    chk("R6 mode 00 no flag", 32'(stat[1]), 0);
    chk("R6 mode 00 no reset", 32'(rst), 0);
    bcfg = 2'b01; brn = 1'b1; cyc(); brn = 1'b0;
    chk("R6 mode 01 soft off", 32'(stat[1]), 0);
    we = 1'b1; wdata = 10'h200; cyc(); we = 1'b0;
    brn = 1'b1; cyc(); brn = 1'b0;
    chk("R6 mode 01 soft on", 32'(stat[1]), 1);
    idle(20);
    we = 1'b1; wdata = 10'h000; cyc(); we = 1'b0;
    bcfg = 2'b10; slp = 1'b1; brn = 1'b1; cyc(); brn = 1'b0;
    chk("R6 mode 10 asleep", 32'(stat[1]), 0);
    chk("R6 mode 10 asleep no reset", 32'(rst), 0);
    slp = 1'b0; brn = 1'b1; cyc(); brn = 1'b0;
    chk("R6 mode 10 awake", 32'(stat[1]), 1);
    idle(20);
    we = 1'b1; wdata = 10'h000; cyc(); we = 1'b0;
    bcfg = 2'b11; slp = 1'b1; brn = 1'b1; cyc(); brn = 1'b0; slp = 1'b0;
    chk("R6 mode 11 always", 32'(stat[1]), 1);
    idle(20);

    cur_req = "R3";
    wdt = 1'b1; cyc(); wdt = 1'b0;
    por = 1'b1; cyc(); por = 1'b0;
    chk("R3 power-on clears causes", 32'(stat), 32'h203);
    idle(20);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule